// File: doc/BRIEF.md
# Fan Tachometer Period Monitor

This block times a fan's tachometer pulse train in system clock cycles. The raw tach input is brought into the clock domain by a two-flop synchronizer. Each rising edge of the synchronized signal closes one period and opens the next. The length of every completed period is published in a read-only measurement register.

Each new measurement raises a measurement event. Software programs an expected period and an absolute tolerance, and a measurement outside that window raises a tach-fault event. Two further event inputs, one for a duty-cycle change and one for a temperature rise, come from neighbouring logic. All four events collect in a pending register that is cleared by writing 1. A mask register gates them onto a level, active-high interrupt line.

Access is through a plain single-cycle register port. A write completes in the cycle that `reg_wr_en` is high. Reads are combinational from `reg_addr`. The block has no streaming data path, so no valid/ready handshake and no back-pressure.

Top module: `fantach_monitor`

## Requirements
- R1: The measurement register (address 2) holds the number of clock cycles between two consecutive synchronized rising edges of `tach_in`. A tach rise presented before clock edge k is visible at the register port after edge k+2.
- R2: The first rising edge after reset, and the first after a timeout, only starts a period. It publishes no measurement and sets no event.
- R3: Every completed measurement, and every timeout, sets pending bit 3 (measurement event).
- R4: With the expected period E (address 0) nonzero and the tolerance T (address 1), a measurement M sets pending bit 1 (tach fault) when M < E - T or M > E + T. Both bounds are inclusive as passes. When T > E the lower bound is 0.
- R5: While E is zero, the window check sets no tach fault.
- R6: If the cycle counter reaches 2^CNT_W - 1 with no rising edge, the block publishes that value and sets pending bits 3 and 1 once, with no repeat while the input stays idle.
- R7: A one-cycle pulse on `evt_pwm_chg` sets pending bit 0, and a pulse on `evt_temp_up` sets pending bit 2, visible one cycle later.
- R8: The mask register (address 3, bits 3:0) resets to 4'hF. A mask bit of 1 keeps its pending bit off the interrupt.
- R9: Writing the pending register (address 4) clears each bit written as 1 and leaves each bit written as 0 unchanged. An event arriving in the same cycle as its clear leaves the bit set.
- R10: `irq` is high exactly while some pending bit is set whose mask bit is 0.
- R11: After reset, E, T, the measurement and the pending register read 0, and `irq` is low.
- R12: Address 4 reads the pending bits. Address 5 reads pending AND NOT mask. Unused addresses read 0, and writes to addresses 2 and 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tach_in | input | 1 | Asynchronous fan tachometer pulse input |
| evt_pwm_chg | input | 1 | Pulse: duty cycle changed (event bit 0) |
| evt_temp_up | input | 1 | Pulse: temperature increase (event bit 2) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| irq | output | 1 | Level interrupt, high while an unmasked event is pending |

## Verification
A tach rise driven before clock edge k reaches the measurement register and pending bits 3 and 1 after edge k+2. That count is two synchronizer flops plus the publishing register. The bench therefore drives on a falling edge and reads on the third falling edge after it. Event pulses and register writes land on the next rising edge and are read on the following falling edge. The interrupt follows pending and mask with no extra register, so it is sampled in that same half cycle. A timeout is due 2^CNT_W - 1 cycles after the last edge, and the bench waits past that point before reading.

// File: rtl/fantach_pkg.sv
package fantach_pkg;
  localparam int NUM_EVT = 4;

  // event bit positions in mask / pending / source
  localparam int EVT_PWM  = 0;
  localparam int EVT_FLT  = 1;
  localparam int EVT_TEMP = 2;
  localparam int EVT_MEAS = 3;

  // register word addresses
  localparam logic [2:0] ADR_EXPECT = 3'd0;
  localparam logic [2:0] ADR_TOLER  = 3'd1;
  localparam logic [2:0] ADR_MEAS   = 3'd2;
  localparam logic [2:0] ADR_MASK   = 3'd3;
  localparam logic [2:0] ADR_PEND   = 3'd4;
  localparam logic [2:0] ADR_SRC    = 3'd5;
endpackage

// File: rtl/fantach_sync.sv
module fantach_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= 1'b0;
      else if (s == 0) chain[s] <= d_async;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/fantach_period.sv
module fantach_period #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tach_s,
  output logic             meas_evt,
  output logic             timeout,
  output logic [CNT_W-1:0] meas_val,
  output logic [CNT_W-1:0] meas_q
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_NEAR = {{(CNT_W-1){1'b1}}, 1'b0};

  logic             prev_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;
  logic             done;

  assign rise     = tach_s & ~prev_q;
  assign done     = armed_q & rise;
  assign timeout  = (cnt_q == CNT_NEAR) & ~rise;
  assign meas_evt = done | timeout;
  assign meas_val = timeout ? CNT_MAX : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      meas_q  <= '0;
    end else begin
      prev_q <= tach_s;
      if (rise) begin
        cnt_q   <= {{(CNT_W-1){1'b0}}, 1'b1};
        armed_q <= 1'b1;
      end else begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        if (timeout) armed_q <= 1'b0;
      end
      if (meas_evt) meas_q <= meas_val;
    end
  end

  // R1: published value only moves on a measurement event
  assert_meas_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_evt |=> $stable(meas_q));

  // R6: saturation reports once, never on two cycles in a row
  assert_sat_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);

  // R2: an edge seen while unarmed never yields a measurement in that cycle
  assert_arm_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && $past(timeout)) |-> !meas_evt);
endmodule

// File: rtl/fantach_window.sv
module fantach_window #(
  parameter int CNT_W = 20
) (
  input  logic [CNT_W-1:0] expect_p,
  input  logic [CNT_W-1:0] toler,
  input  logic [CNT_W-1:0] value,
  output logic             out_of_range
);
  logic [CNT_W:0] upper;
  logic           below;
  logic           above;

  assign upper = {1'b0, expect_p} + {1'b0, toler};
  assign below = (toler <= expect_p) && (value < (expect_p - toler));
  assign above = ({1'b0, value} > upper);
  assign out_of_range = (expect_p != '0) && (below || above);
endmodule

// File: rtl/fantach_irq.sv
module fantach_irq
  import fantach_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               mask_we,
  input  logic [NUM_EVT-1:0] mask_wdata,
  input  logic [NUM_EVT-1:0] pend_clr,
  output logic [NUM_EVT-1:0] mask_q,
  output logic [NUM_EVT-1:0] pend_q,
  output logic               irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      pend_q <= (pend_q & ~pend_clr) | evt;
    end
  end

  assign irq = |(pend_q & ~mask_q);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_chk
    // R9: an event wins over a clear in the same cycle
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> pend_q[i]);
    // R9: write-1 clears when no event arrives
    assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_clr[i] && !evt[i]) |=> !pend_q[i]);
  end
endmodule

// File: rtl/fantach_monitor.sv
module fantach_monitor
  import fantach_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tach_in,
  input  logic              evt_pwm_chg,
  input  logic              evt_temp_up,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic             tach_s;
  logic             meas_evt;
  logic             timeout;
  logic [CNT_W-1:0] meas_val;
  logic [CNT_W-1:0] meas_q;
  logic             win_oor;
  logic             flt_evt;
  logic [CNT_W-1:0] expect_q;
  logic [CNT_W-1:0] toler_q;
  logic [NUM_EVT-1:0] evt_vec;
  logic [NUM_EVT-1:0] mask_q;
  logic [NUM_EVT-1:0] pend_q;
  logic [NUM_EVT-1:0] pend_clr;
  logic             mask_we;
  logic [2:0]       adr;
  logic             unused_wdata_hi;

  assign adr = 3'(reg_addr);
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CNT_W];

  fantach_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(tach_in), .q_sync(tach_s)
  );

  fantach_period #(.CNT_W(CNT_W)) u_period (
    .clk(clk), .rst_n(rst_n), .tach_s(tach_s), .meas_evt(meas_evt),
    .timeout(timeout), .meas_val(meas_val), .meas_q(meas_q)
  );

  fantach_window #(.CNT_W(CNT_W)) u_window (
    .expect_p(expect_q), .toler(toler_q), .value(meas_val),
    .out_of_range(win_oor)
  );

  assign flt_evt = meas_evt & (timeout | win_oor);

  always_comb begin
    evt_vec           = '0;
    evt_vec[EVT_PWM]  = evt_pwm_chg;
    evt_vec[EVT_FLT]  = flt_evt;
    evt_vec[EVT_TEMP] = evt_temp_up;
    evt_vec[EVT_MEAS] = meas_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      expect_q <= '0;
      toler_q  <= '0;
    end else if (reg_wr_en) begin
      if (adr == ADR_EXPECT) expect_q <= reg_wdata[CNT_W-1:0];
      if (adr == ADR_TOLER)  toler_q  <= reg_wdata[CNT_W-1:0];
    end
  end

  assign mask_we  = reg_wr_en && (adr == ADR_MASK);
  assign pend_clr = (reg_wr_en && (adr == ADR_PEND)) ? reg_wdata[NUM_EVT-1:0] : '0;

  fantach_irq u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt_vec), .mask_we(mask_we),
    .mask_wdata(reg_wdata[NUM_EVT-1:0]), .pend_clr(pend_clr),
    .mask_q(mask_q), .pend_q(pend_q), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (adr)
      ADR_EXPECT: reg_rdata[CNT_W-1:0]   = expect_q;
      ADR_TOLER:  reg_rdata[CNT_W-1:0]   = toler_q;
      ADR_MEAS:   reg_rdata[CNT_W-1:0]   = meas_q;
      ADR_MASK:   reg_rdata[NUM_EVT-1:0] = mask_q;
      ADR_PEND:   reg_rdata[NUM_EVT-1:0] = pend_q;
      ADR_SRC:    reg_rdata[NUM_EVT-1:0] = pend_q & ~mask_q;
      default:    reg_rdata = '0;
    endcase
  end

  // R5: the window never reports a fault while the expected period is zero
  assert_no_check_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_oor |-> (expect_q != '0));

  // R8: a fully masked register set keeps the line low
  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq);

  // R3: a fault event is always accompanied by a measurement event
  assert_fault_with_meas_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flt_evt |=> (pend_q[EVT_MEAS] && pend_q[EVT_FLT]));
endmodule

// File: tb/sim_fantach_monitor.sv
module sim_fantach_monitor;
  localparam int CW = 10;
  localparam int DW = 32;
  localparam int SAT = (1 << CW) - 1;
  localparam int NV = 10;
  // expected, tolerance, period, fault expected
  localparam int VEC [0:NV-1][0:3] = '{
    '{100, 25, 100, 0}, '{100, 25, 75, 0}, '{100, 25, 74, 1},
    '{100, 25, 125, 0}, '{100, 25, 126, 1}, '{0, 0, 60, 0},
    '{40, 50, 20, 0},   '{40, 50, 91, 1},   '{200, 0, 200, 0},
    '{200, 0, 201, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tach_in = 1'b0;
  logic evt_pwm_chg = 1'b0;
  logic evt_temp_up = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fantach_monitor #(.CNT_W(CW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .evt_pwm_chg(evt_pwm_chg),
    .evt_temp_up(evt_temp_up), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // rise A, clear pending, rise B exactly p cycles after A, wait for publish
  task automatic run_interval(input int e, input int t, input int p);
    wr(3'd0, e);
    wr(3'd1, t);
    tach_in = 1'b1;
    repeat (2) @(negedge clk);
    tach_in = 1'b0;
    repeat (2) @(negedge clk);
    wr(3'd4, 32'hF);
    repeat (p - 5) @(negedge clk);
    tach_in = 1'b1;
    repeat (3) @(negedge clk);
    tach_in = 1'b0;
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_up();
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    rd(3'd0, v); chk("R11 expected", v, 0);
    rd(3'd1, v); chk("R11 tolerance", v, 0);
    rd(3'd2, v); chk("R11 measurement", v, 0);
    rd(3'd4, v); chk("R11 pending", v, 0);
    chk("R11 irq", irq, 0);
    rd(3'd3, v); chk("R8 mask reset", v, 32'hF);

    // R2: first edge after reset only arms
    tach_in = 1'b1;
    repeat (2) @(negedge clk);
    tach_in = 1'b0;
    repeat (8) @(negedge clk);
    rd(3'd4, v); chk("R2 no event after reset edge", v, 0);
    rd(3'd2, v); chk("R2 no measurement after reset edge", v, 0);

    // R7 event inputs
    evt_pwm_chg = 1'b1; @(negedge clk); evt_pwm_chg = 1'b0;
    rd(3'd4, v); chk("R7 pwm event bit0", v, 32'h1);
    evt_temp_up = 1'b1; @(negedge clk); evt_temp_up = 1'b0;
    rd(3'd4, v); chk("R7 temp event bit2", v, 32'h5);
    chk("R8 masked irq low", irq, 0);
    // R10 / R12
    wr(3'd3, 32'hE);
    chk("R10 unmasked bit0 raises irq", irq, 1);
    rd(3'd5, v); chk("R12 source = pend & ~mask", v, 32'h1);
    wr(3'd5, 32'hF);
    rd(3'd4, v); chk("R12 write to source ignored", v, 32'h5);
    wr(3'd4, 32'h0);
    rd(3'd4, v); chk("R9 write 0 keeps bits", v, 32'h5);
    wr(3'd4, 32'h1);
    rd(3'd4, v); chk("R9 write 1 clears bit0 only", v, 32'h4);
    chk("R10 irq drops with bit0", irq, 0);
    evt_pwm_chg = 1'b1;
    wr(3'd4, 32'h1);
    evt_pwm_chg = 1'b0;
    rd(3'd4, v); chk("R9 set wins over clear", v, 32'h5);
    rd(3'd6, v); chk("R12 unused address reads 0", v, 0);
    wr(3'd3, 32'hF);
    wr(3'd4, 32'hF);
    rd(3'd4, v); chk("R9 clear all", v, 0);

    // vector table: R1, R3, R4, R5
    for (int i = 0; i < NV; i++) begin
      run_interval(VEC[i][0], VEC[i][1], VEC[i][2]);
      rd(3'd2, v); chk($sformatf("R1 period vec%0d", i), v, VEC[i][2]);
      rd(3'd4, v);
      chk($sformatf("R3 meas bit vec%0d", i), v[3], 1);
      chk($sformatf("R4 R5 fault bit vec%0d", i), v[1], VEC[i][3]);
      rd(3'd2, v);
      wr(3'd2, 32'h5);
      rd(3'd2, v); chk("R12 write to measurement ignored", v, VEC[i][2]);
    end

    // R6 timeout
    wr(3'd0, 100);
    wr(3'd4, 32'hF);
    repeat (1100) @(negedge clk);
    rd(3'd2, v); chk("R6 saturated value", v, SAT);
    rd(3'd4, v); chk("R6 fault and meas bits", v, 32'hA);
    wr(3'd4, 32'hF);
    repeat (50) @(negedge clk);
    rd(3'd4, v); chk("R6 reported once", v, 0);
    // R2 after timeout
    tach_in = 1'b1;
    repeat (2) @(negedge clk);
    tach_in = 1'b0;
    repeat (10) @(negedge clk);
    rd(3'd4, v); chk("R2 no event after timeout edge", v, 0);
    run_interval(100, 25, 100);
    rd(3'd2, v); chk("R2 R1 measures after rearm", v, 100);
    rd(3'd4, v); chk("R4 in window after rearm", v, 32'h8);

    done = 1'b1;
    finish_up();
  end
endmodule